// File: doc/BRIEF.md
# Clocked serial continuous receiver

This block receives synchronous serial frames. A serial clock and a data line come from outside. Both are brought into the system clock domain, and the data line is sampled on each rising edge of the serial clock. Frames are shifted in either most-significant bit first or least-significant bit first. A 4-bit length code sets the frame length. Each completed frame lands right-aligned and zero-extended in a receive word that the host reads.

The block must first be enabled, with receive enabled. Reception then starts on the host's first read strobe of the receive word, which acts as a trigger and carries no data. From then on, frames follow one another with no further trigger. Every frame that completes raises either a one-cycle completion interrupt or, if the host has not read the previous frame, a one-cycle error interrupt. The error interrupt also sets a sticky overrun flag. A busy flag shows when a frame is partly shifted, so software can wait for it to clear before turning the block off.

Top module: `csi_rx_cont`

## Requirements
- R1: After reset, rx_data, busy, ovr_flag, irq_done and irq_err are all 0.
- R2: With cfg_en=1 and cfg_rxe=1 but no read strobe since enabling, serial clock edges shift nothing: busy stays 0, no interrupt fires and rx_data is unchanged.
- R3: With cfg_lsb_first=0, the first received bit ends up as the most significant bit of the frame. Length code 0 gives 8-bit frames, and the bits 0,1,0,1,0,1,0,1 read as 0x55.
- R4: With cfg_lsb_first=1, the first received bit ends up in bit 0 of rx_data.
- R5: A nonzero length code n gives n-bit frames. No interrupt fires before the n-th bit, and the result sits in rx_data[n-1:0] with the upper bits 0.
- R6: When a frame completes, rx_data takes the new frame on the same clock edge that raises the interrupt. That edge is the third system clock edge after the rising serial clock edge that carries the last bit, counting the first edge at which the rising clock is present at the input. irq_done is high for one cycle. rx_data changes only on a cycle in which an interrupt is high.
- R7: After the trigger read, frames keep arriving without further triggers. Each completed frame whose predecessor was read gives exactly one irq_done.
- R8: If the previous frame has not been read when a frame completes, that frame still overwrites rx_data, irq_err pulses, ovr_flag becomes 1 and irq_done does not fire.
- R9: ovr_flag stays 1 until an ovr_clr strobe clears it.
- R10: busy is 1 while a frame is partly received and 0 once it has completed.
- R11: Clearing cfg_en discards partial bits and clears busy on the next cycle, and leaves rx_data untouched. After re-enabling, a new trigger read is needed before reception resumes.
- R12: irq_done and irq_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Block operation enable |
| cfg_rxe | input | 1 | Receive enable |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_len | input | LEN_W | Frame length code, 0 means 8 bits |
| sclk_in | input | 1 | External serial clock |
| sdata_in | input | 1 | External serial data |
| rd_stb | input | 1 | Host read of the receive word (trigger and acknowledge) |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 2**LEN_W-1 | Last received frame, right-aligned |
| busy | output | 1 | Frame partly shifted |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq_done | output | 1 | Frame-complete interrupt pulse |
| irq_err | output | 1 | Overrun interrupt pulse |

## Verification
Every result follows from a rising serial clock edge through a fixed pipeline. The interrupt and the new rx_data are due on the third system edge after the edge the bench drives, and the bench measures that gap for the last bit of a frame. The bench changes inputs only at falling system edges. It holds each serial clock phase for four cycles and counts interrupt pulses at falling edges. Because of this, every flag and data check runs several cycles after the result is due, so none of them depends on the exact moment of the update. Busy is checked between bits of a partial frame and one bit before the end of a short frame, where no update can be pending.

// File: rtl/csi_rx_pkg.sv
package csi_rx_pkg;
  // Number of bits in a frame for a given length code.
  function automatic int frame_bits(input int code, input int dflt_bits);
    return (code == 0) ? dflt_bits : code;
  endfunction
endpackage

// File: rtl/csi_rx_sync.sv
module csi_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic rise_evt,
  output logic bit_val
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q    <= '0;
      dt_q    <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_q    <= {ck_q[STAGES-2:0], sclk_in};
      dt_q    <= {dt_q[STAGES-2:0], sdata_in};
      ck_prev <= ck_q[STAGES-1];
    end
  end

  assign rise_evt = ck_q[STAGES-1] & ~ck_prev;
  assign bit_val  = dt_q[STAGES-1];
endmodule

// File: rtl/csi_rx_shift.sv
module csi_rx_shift #(
  parameter int LEN_W     = 4,
  parameter int DFLT_BITS = 8,
  localparam int DATA_W   = (1 << LEN_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              rise_evt,
  input  logic              bit_val,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_word,
  output logic              in_frame
);
  import csi_rx_pkg::*;

  logic [LEN_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nxt;
  logic              last_bit;

  always_comb begin
    sh_nxt = sh_q;
    if (lsb_first) sh_nxt[cnt_q] = bit_val;
    else           sh_nxt = {sh_q[DATA_W-2:0], bit_val};
  end

  assign last_bit   = int'(cnt_q) == frame_bits(int'(len_code), DFLT_BITS) - 1;
  assign frame_done = active && rise_evt && last_bit;
  assign frame_word = sh_nxt;
  assign in_frame   = cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!active) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (rise_evt) begin
      if (last_bit) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= sh_nxt;
      end
    end
  end
endmodule

// File: rtl/csi_rx_ctrl.sv
module csi_rx_ctrl #(
  parameter int DATA_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_rxe,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_word,
  output logic              active,
  output logic [DATA_W-1:0] rx_data,
  output logic              ovr_flag,
  output logic              irq_done,
  output logic              irq_err
);
  logic started_q;
  logic unread_q;
  logic ovr_hit;

  assign active  = cfg_en && cfg_rxe && started_q;
  // A read in the same cycle consumes the previous frame.
  assign ovr_hit = frame_done && unread_q && !rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      unread_q  <= 1'b0;
      rx_data   <= '0;
      ovr_flag  <= 1'b0;
      irq_done  <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      if (!(cfg_en && cfg_rxe)) started_q <= 1'b0;
      else if (rd_stb)          started_q <= 1'b1;

      if (frame_done)  unread_q <= 1'b1;
      else if (rd_stb) unread_q <= 1'b0;

      if (frame_done) rx_data <= frame_word;

      irq_done <= frame_done && !ovr_hit;
      irq_err  <= ovr_hit;

      if (ovr_hit)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/csi_rx_cont.sv
module csi_rx_cont #(
  parameter int LEN_W       = 4,
  parameter int DFLT_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = (1 << LEN_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_rxe,
  input  logic              cfg_lsb_first,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              ovr_flag,
  output logic              irq_done,
  output logic              irq_err
);
  logic              rise_evt;
  logic              bit_val;
  logic              active;
  logic              frame_done;
  logic [DATA_W-1:0] frame_word;

  csi_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .rise_evt(rise_evt), .bit_val(bit_val)
  );

  csi_rx_shift #(.LEN_W(LEN_W), .DFLT_BITS(DFLT_BITS)) shift_i (
    .clk(clk), .rst_n(rst_n), .active(active), .lsb_first(cfg_lsb_first),
    .len_code(cfg_len), .rise_evt(rise_evt), .bit_val(bit_val),
    .frame_done(frame_done), .frame_word(frame_word), .in_frame(busy)
  );

  csi_rx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rxe(cfg_rxe),
    .rd_stb(rd_stb), .ovr_clr(ovr_clr), .frame_done(frame_done),
    .frame_word(frame_word), .active(active), .rx_data(rx_data),
    .ovr_flag(ovr_flag), .irq_done(irq_done), .irq_err(irq_err)
  );
endmodule

// File: rtl/csi_rx_cont_chk.sv
module csi_rx_cont_chk #(
  parameter int DATA_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              ovr_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              busy,
  input logic              ovr_flag,
  input logic              irq_done,
  input logic              irq_err
);
  // R12
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_err));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  // R6
  data_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data != $past(rx_data)) |-> (irq_done || irq_err));

  // R8
  err_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> ovr_flag);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !busy);
endmodule

bind csi_rx_cont csi_rx_cont_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ovr_clr(ovr_clr),
  .rx_data(rx_data), .busy(busy), .ovr_flag(ovr_flag),
  .irq_done(irq_done), .irq_err(irq_err)
);

// File: tb/csi_rx_cont_tb.sv
module csi_rx_cont_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 4;
  localparam int DW = (1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_rxe = 1'b0, cfg_lsb_first = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic sclk_in = 1'b0, sdata_in = 1'b0, rd_stb = 1'b0, ovr_clr = 1'b0;
  logic [DW-1:0] rx_data;
  logic busy, ovr_flag, irq_done, irq_err;

  int checks = 0, failures = 0;
  int cyc = 0, done_cnt = 0, err_cnt = 0;
  int last_rise = 0, last_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (irq_done) begin done_cnt++; last_done = cyc; end
    if (irq_err) err_cnt++;
  end

  csi_rx_cont #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rxe(cfg_rxe),
    .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .rd_stb(rd_stb), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .busy(busy), .ovr_flag(ovr_flag),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk) sdata_in = b;
    repeat (2) @(negedge clk);
    sclk_in = 1'b1; last_rise = cyc;
    repeat (4) @(negedge clk);
    sclk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Sends nb bits of v, in the order set by lsb.
  task automatic send_frame(input int v, input int nb, input bit lsb);
    for (int i = 0; i < nb; i++)
      send_bit(lsb ? v[i] : v[nb-1-i]);
  endtask

  task automatic host_read();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk(rx_data == '0, "R1", "rx_data", int'(rx_data), 0);
    chk({busy, ovr_flag, irq_done, irq_err} == 4'b0, "R1", "flags",
        int'({busy, ovr_flag, irq_done, irq_err}), 0);
  endtask

  task automatic t_no_trigger();
    @(negedge clk) begin cfg_en = 1'b1; cfg_rxe = 1'b1; end
    send_frame(8'h5A, 8, 1'b0);
    chk(done_cnt == 0 && err_cnt == 0, "R2", "irq count", done_cnt + err_cnt, 0);
    chk(rx_data == '0, "R2", "rx_data", int'(rx_data), 0);
    chk(busy == 1'b0, "R2", "busy", int'(busy), 0);
  endtask

  task automatic t_msb();
    host_read();
    send_frame(8'h55, 8, 1'b0);
    chk(rx_data == DW'(8'h55), "R3", "rx_data msb", int'(rx_data), 'h55);
    chk(done_cnt == 1, "R6", "irq_done count", done_cnt, 1);
    chk(last_done - last_rise == 3, "R6", "irq latency", last_done - last_rise, 3);
    chk(busy == 1'b0, "R10", "busy after frame", int'(busy), 0);
  endtask

  task automatic t_continuous();
    host_read();
    send_frame(8'hAA, 8, 1'b0);
    chk(rx_data == DW'(8'hAA), "R7", "second frame", int'(rx_data), 'hAA);
    chk(done_cnt == 2 && err_cnt == 0, "R7", "irq_done count", done_cnt, 2);
    host_read();
  endtask

  task automatic t_overrun();
    send_frame(8'h3C, 8, 1'b0);
    chk(done_cnt == 3, "R7", "frame 3 irq", done_cnt, 3);
    send_frame(8'hC3, 8, 1'b0);
    chk(ovr_flag == 1'b1, "R8", "ovr_flag", int'(ovr_flag), 1);
    chk(err_cnt == 1, "R8", "irq_err count", err_cnt, 1);
    chk(done_cnt == 3, "R8", "no irq_done on overrun", done_cnt, 3);
    chk(rx_data == DW'(8'hC3), "R8", "overwritten data", int'(rx_data), 'hC3);
    host_read();
    repeat (20) @(negedge clk);
    chk(ovr_flag == 1'b1, "R9", "flag held", int'(ovr_flag), 1);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk(ovr_flag == 1'b0, "R9", "flag cleared", int'(ovr_flag), 0);
  endtask

  task automatic t_lsb();
    @(negedge clk) cfg_lsb_first = 1'b1;
    send_frame(8'h1B, 8, 1'b1);
    chk(rx_data == DW'(8'h1B), "R4", "rx_data lsb", int'(rx_data), 'h1B);
    host_read();
    @(negedge clk) cfg_lsb_first = 1'b0;
  endtask

  task automatic t_len();
    int d0;
    @(negedge clk) cfg_len = 4'd5;
    d0 = done_cnt;
    send_frame(5'h13 >> 1, 4, 1'b0);
    chk(done_cnt == d0, "R5", "no irq before bit 5", done_cnt, d0);
    chk(busy == 1'b1, "R10", "busy mid frame", int'(busy), 1);
    send_bit(1'b1);
    chk(done_cnt == d0 + 1, "R5", "irq at bit 5", done_cnt, d0 + 1);
    chk(rx_data == DW'(5'h13), "R5", "5-bit word", int'(rx_data), 'h13);
    host_read();
    @(negedge clk) cfg_len = 4'd0;
  endtask

  task automatic t_disable();
    int d0;
    d0 = done_cnt;
    send_frame(3'b111, 3, 1'b0);
    chk(busy == 1'b1, "R10", "busy partial", int'(busy), 1);
    @(negedge clk) cfg_en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R11", "busy cleared", int'(busy), 0);
    chk(rx_data == DW'(5'h13), "R11", "rx_data kept", int'(rx_data), 'h13);
    @(negedge clk) cfg_en = 1'b1;
    send_frame(8'hFF, 8, 1'b0);
    chk(done_cnt == d0, "R11", "needs new trigger", done_cnt, d0);
    host_read();
    send_frame(8'h81, 8, 1'b0);
    chk(rx_data == DW'(8'h81), "R11", "partial bits discarded", int'(rx_data), 'h81);
    chk(done_cnt == d0 + 1 && ovr_flag == 1'b0, "R11", "clean restart", done_cnt, d0 + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_no_trigger();
    t_msb();
    t_continuous();
    t_overrun();
    t_lsb();
    t_len();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule